// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers eight interrupt sources for a small processor core and reduces them to a single vectored request. Two of the sources are active-low external pins. Each pin has its own trigger selection, either a falling edge or a low level. The other six sources are internal strobes. Every source latches into a pending flag. The controller then picks one winner and presents its 3-bit source index to the execution unit. It holds that request until the core signals, at an instruction boundary, that it has taken the interrupt.

Each source carries a priority bit that selects one of two levels. The controller remembers which levels have a service routine in progress. A high-level request may interrupt a low-level routine. A high-level routine cannot be interrupted by anything. A return strobe from the core ends the innermost running routine. Source 7 cannot be masked and is always treated as the strongest request. Sources 0 to 6 are gated both by their own enable bit and by a global enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irqReq`, `busyHigh` and `busyLow` are all low.
- R2: When `extEdgeMode[i]` is 1, a high-to-low transition on `extReqN[i]` sets the pending flag of source i (pin i is source i, i = 0 or 1). That flag is cleared when source i is acknowledged. A pin that stays low after acknowledge does not raise a second request.
- R3: When `extEdgeMode[i]` is 0, the pending flag of source i follows the synchronized inverse of the pin. Acknowledge does not clear it. A pin that is still low raises a new request once the level is free again. A pin that has returned high raises none.
- R4: A source from 0 to 6 is requested only while `globalEnable` is 1 and its `srcEnable` bit is 1. Masking a source keeps its flag, and the source is requested once it is unmasked. Source 7 is requested whatever its enable bit and `globalEnable` hold.
- R5: Among the sources that may be requested, a high-level source (`srcPrioHigh` bit 1) beats a low-level source. Within one level, the lower index wins. Source 7 counts as high level and wins over every other source.
- R6: Once `irqReq` is high, it stays high with `irqSrc` and `irqHigh` unchanged until a cycle in which `irqAck` is high. This holds even if a stronger request arrives in the meantime.
- R7: A cycle with `irqReq` and `irqAck` both high drops `irqReq` on the next edge and sets `busyHigh` or `busyLow` according to `irqHigh`. The same acknowledge clears an edge or internal pending flag of the granted source. Internal source j (2 to 7) is set by a one-cycle pulse on `intReq[j-2]`.
- R8: No request is raised while `busyHigh` is 1. While `busyLow` is 1, only high-level sources are requested.
- R9: A cycle with `retiStrobe` high clears `busyHigh` if it is set, and otherwise clears `busyLow`.
- R10: A pin that goes low before rising edge k raises `irqReq` after edge k+3. The path is a two-flop synchronizer, a flag stage and a request stage. An internal pulse raises `irqReq` after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extReqN | input | 2 | Active-low external request pins, bit i is source i |
| extEdgeMode | input | 2 | Per pin: 1 = falling edge, 0 = low level |
| intReq | input | 6 | Internal set pulses, bit j-2 is source j |
| srcEnable | input | 8 | Per-source enable; bit 7 is ignored |
| srcPrioHigh | input | 8 | Per-source level: 1 = high, 0 = low |
| globalEnable | input | 1 | Gates sources 0 to 6 |
| irqAck | input | 1 | Core accepts the presented request at an instruction boundary |
| retiStrobe | input | 1 | Core finished the innermost service routine |
| irqReq | output | 1 | Vectored request to the core |
| irqSrc | output | 3 | Index of the requested source |
| irqHigh | output | 1 | Level of the requested source |
| busyHigh | output | 1 | High-level routine in progress |
| busyLow | output | 1 | Low-level routine in progress |

## Verification
The in-progress levels are observed directly at `busyHigh` and `busyLow` one edge after an acknowledge or return. A wrong pending flag shows within one cycle of the level becoming free: either an extra request or a missing request appears at `irqReq`. A wrong arbitration result appears as a wrong `irqSrc` or `irqHigh` on the first cycle the request is visible. Because the request is committed until acknowledge, a winner chosen from the wrong state is visible for the whole hold window, not just for one cycle.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } irq_lvl_e;

  // control -> datapath: acknowledge of one source
  typedef struct packed {
    logic             clrValid;
    logic [IDX_W-1:0] clrIdx;
  } irq_strobe_t;
endpackage

// File: rtl/irq_prio_datapath.sv
`timescale 1ns/1ps
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned NUM_EXT     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extReqN,
  input  logic [NUM_EXT-1:0]         extEdgeMode,
  input  logic [NUM_SRC-NUM_EXT-1:0] intReq,
  input  irq_strobe_t                ctlStb,
  output logic [NUM_SRC-1:0]         pendFlags
);

  // pins: synchronizer chain plus one history stage for edge detection
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    logic [SYNC_STAGES:0] chainQ;
    logic                 pinLow;
    logic                 fallSeen;
    logic                 clrHit;
    logic                 pendQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= '1;
      else       chainQ <= {chainQ[SYNC_STAGES-1:0], extReqN[e]};
    end

    assign pinLow   = !chainQ[SYNC_STAGES-1];
    assign fallSeen = chainQ[SYNC_STAGES] && !chainQ[SYNC_STAGES-1];
    assign clrHit   = ctlStb.clrValid && (ctlStb.clrIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               pendQ <= 1'b0;
      else if (extEdgeMode[e]) pendQ <= fallSeen || (pendQ && !clrHit);
      else                     pendQ <= pinLow;
    end

    assign pendFlags[e] = pendQ;

    // R7: acknowledge drops an edge flag unless a new edge coincides
    p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      extEdgeMode[e] && clrHit && !fallSeen |=> !pendQ);

    // R2: an edge flag stays set until its acknowledge
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      extEdgeMode[e] && pendQ && !clrHit |=> pendQ);
  end

  // internal sources: set by pulse, cleared by acknowledge, set wins
  for (genvar s = NUM_EXT; s < NUM_SRC; s++) begin : g_int
    logic clrHit;
    logic pendQ;

    assign clrHit = ctlStb.clrValid && (ctlStb.clrIdx == IDX_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ <= 1'b0;
      else       pendQ <= intReq[s-NUM_EXT] || (pendQ && !clrHit);
    end

    assign pendFlags[s] = pendQ;

    p_int_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      clrHit && !intReq[s-NUM_EXT] |=> !pendQ);
  end

endmodule

// File: rtl/irq_prio_control.sv
`timescale 1ns/1ps
module irq_prio_control
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int          NMI_SRC = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendFlags,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcPrioHigh,
  input  logic               globalEnable,
  input  logic               irqAck,
  input  logic               retiStrobe,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqSrc,
  output logic               irqHigh,
  output logic               busyHigh,
  output logic               busyLow,
  output irq_strobe_t        ctlStb
);

  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] effHigh;
  logic               hiFound, loFound;
  logic [IDX_W-1:0]   hiIdx, loIdx;
  logic               candValid, candHigh;
  logic [IDX_W-1:0]   candIdx;

  logic               reqQ;
  logic [IDX_W-1:0]   srcQ;
  irq_lvl_e           lvlQ;
  logic [1:0]         busyQ;   // [1] high, [0] low
  logic [1:0]         busyNext;
  logic               grant;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      eligible[i] = pendFlags[i] && ((i == NMI_SRC) || (globalEnable && srcEnable[i]));
      effHigh[i]  = (i == NMI_SRC) || srcPrioHigh[i];
    end
  end

  // lowest index wins inside each level; the unmaskable source overrides
  always_comb begin
    hiFound = 1'b0;
    loFound = 1'b0;
    hiIdx   = '0;
    loIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && effHigh[i]) begin
        hiFound = 1'b1;
        hiIdx   = IDX_W'(i);
      end
      if (eligible[i] && !effHigh[i]) begin
        loFound = 1'b1;
        loIdx   = IDX_W'(i);
      end
    end
    if (eligible[NMI_SRC]) begin
      hiFound = 1'b1;
      hiIdx   = IDX_W'(NMI_SRC);
    end
    candHigh  = hiFound;
    candIdx   = hiFound ? hiIdx : loIdx;
    candValid = hiFound ? !busyQ[1] : (loFound && !busyQ[1] && !busyQ[0]);
  end

  assign grant = reqQ && irqAck;

  always_comb begin
    busyNext = busyQ;
    if (retiStrobe) begin
      if (busyNext[1]) busyNext[1] = 1'b0;
      else             busyNext[0] = 1'b0;
    end
    if (grant) begin
      if (lvlQ == LVL_HIGH) busyNext[1] = 1'b1;
      else                  busyNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ  <= 1'b0;
      srcQ  <= '0;
      lvlQ  <= LVL_LOW;
      busyQ <= 2'b00;
    end else begin
      busyQ <= busyNext;
      if (!reqQ) begin
        if (candValid) begin
          reqQ <= 1'b1;
          srcQ <= candIdx;
          lvlQ <= candHigh ? LVL_HIGH : LVL_LOW;
        end
      end else if (irqAck) begin
        reqQ <= 1'b0;
      end
    end
  end

  assign irqReq          = reqQ;
  assign irqSrc          = srcQ;
  assign irqHigh         = (lvlQ == LVL_HIGH);
  assign busyHigh        = busyQ[1];
  assign busyLow         = busyQ[0];
  assign ctlStb.clrValid = grant;
  assign ctlStb.clrIdx   = srcQ;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && !irqAck |=> reqQ && $stable(srcQ) && $stable(lvlQ));

  p_grant_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    grant && (lvlQ == LVL_HIGH) |=> busyQ[1] && !reqQ);

  p_grant_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    grant && (lvlQ == LVL_LOW) |=> busyQ[0] && !reqQ);

  p_high_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqQ) |-> !$past(busyQ[1]));

  p_low_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqQ) && (lvlQ == LVL_LOW) |-> !$past(busyQ[0]));

  p_nmi_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    !reqQ && candValid && eligible[NMI_SRC] |=> srcQ == IDX_W'(NMI_SRC));

  p_reti_r9: assert property (@(posedge clk) disable iff (!rstN)
    retiStrobe && busyQ[1] && !grant |=> !busyQ[1]);

endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned NUM_EXT     = 2,
  parameter int          NMI_SRC     = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_INT    = NUM_SRC - NUM_EXT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extReqN,
  input  logic [NUM_EXT-1:0] extEdgeMode,
  input  logic [NUM_INT-1:0] intReq,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcPrioHigh,
  input  logic               globalEnable,
  input  logic               irqAck,
  input  logic               retiStrobe,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqSrc,
  output logic               irqHigh,
  output logic               busyHigh,
  output logic               busyLow
);

  logic [NUM_SRC-1:0] pendFlags;
  irq_strobe_t        ctlStb;

  irq_prio_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .extReqN(extReqN), .extEdgeMode(extEdgeMode),
    .intReq(intReq), .ctlStb(ctlStb), .pendFlags(pendFlags)
  );

  irq_prio_control #(
    .NUM_SRC(NUM_SRC), .NMI_SRC(NMI_SRC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .pendFlags(pendFlags), .srcEnable(srcEnable),
    .srcPrioHigh(srcPrioHigh), .globalEnable(globalEnable), .irqAck(irqAck),
    .retiStrobe(retiStrobe), .irqReq(irqReq), .irqSrc(irqSrc), .irqHigh(irqHigh),
    .busyHigh(busyHigh), .busyLow(busyLow), .ctlStb(ctlStb)
  );

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] extReqN = 2'b11;
  logic [1:0] extEdgeMode = 2'b11;
  logic [5:0] intReq = '0;
  logic [7:0] srcEnable = 8'hFF;
  logic [7:0] srcPrioHigh = 8'h00;
  logic       globalEnable = 1'b1;
  logic       irqAck = 1'b0;
  logic       retiStrobe = 1'b0;
  logic       irqReq;
  logic [2:0] irqSrc;
  logic       irqHigh;
  logic       busyHigh;
  logic       busyLow;

  int  checks = 0;
  int  fails = 0;
  bit  autoAck = 1'b0;
  bit  ackOnce = 1'b0;

  typedef struct {
    int    src;
    bit    high;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;   // 250 MHz

  irq_prio_ctrl u_dut (
    .clk(clk), .rstN(rstN), .extReqN(extReqN), .extEdgeMode(extEdgeMode),
    .intReq(intReq), .srcEnable(srcEnable), .srcPrioHigh(srcPrioHigh),
    .globalEnable(globalEnable), .irqAck(irqAck), .retiStrobe(retiStrobe),
    .irqReq(irqReq), .irqSrc(irqSrc), .irqHigh(irqHigh),
    .busyHigh(busyHigh), .busyLow(busyLow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: models the core, pops the scoreboard on each presented request
  always @(negedge clk) begin
    exp_t e;
    if (autoAck && irqReq && !irqAck) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5 unexpected request src", int'(irqSrc), -1);
      end else begin
        e = expQ.pop_front();
        chk(int'(irqSrc) == e.src, {e.tag, " source"}, int'(irqSrc), e.src);
        chk(irqHigh == e.high, {e.tag, " level"}, int'(irqHigh), int'(e.high));
      end
      irqAck = 1'b1;
    end else if (ackOnce) begin
      irqAck  = 1'b1;
      ackOnce = 1'b0;
    end else begin
      irqAck = 1'b0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(input int src, input bit high, input string tag);
    exp_t e;
    e.src = src; e.high = high; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drain_to(input int left, input string tag);
    int n = 0;
    while (expQ.size() > left && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(expQ.size() == left, {tag, " scoreboard drain"}, expQ.size(), left);
    @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (irqReq) seen = 1'b1;
    end
    chk(!seen, {tag, " no request"}, int'(seen), 0);
  endtask

  task automatic pulse(input int src);
    intReq[src-2] = 1'b1;
    @(negedge clk);
    intReq[src-2] = 1'b0;
  endtask

  task automatic reti();
    retiStrobe = 1'b1;
    @(negedge clk);
    retiStrobe = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    chk(!busyHigh && !busyLow, {tag, " levels free"}, {busyHigh, busyLow}, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk(!irqReq, "R1 irqReq after reset", int'(irqReq), 0);
    chk(!busyHigh && !busyLow, "R1 busy after reset", {busyHigh, busyLow}, 0);

    // R10 / R2: edge pin latency, manual acknowledge
    extReqN[0] = 1'b0;
    tick(3);
    chk(!irqReq, "R10 no request before edge k+3", int'(irqReq), 0);
    tick(1);
    chk(irqReq && irqSrc == 3'd0, "R10 request after edge k+3", {irqReq, irqSrc}, 8);
    ackOnce = 1'b1;
    tick(3);
    chk(busyLow && !busyHigh, "R7 low level busy after ack", {busyHigh, busyLow}, 1);
    chk(!irqReq, "R7 request dropped after ack", int'(irqReq), 0);
    reti();
    chk(!busyLow, "R9 reti frees low level", int'(busyLow), 0);
    quiet(8, "R2 edge flag cleared, pin still low");
    extReqN[0] = 1'b1;
    tick(4);

    autoAck = 1'b1;

    // R3 level mode: flag follows pin, survives acknowledge
    extEdgeMode[0] = 1'b0;
    expect_irq(0, 1'b0, "R3 level first");
    extReqN[0] = 1'b0;
    drain_to(0, "R3");
    expect_irq(0, 1'b0, "R3 level retaken after reti");
    reti();
    drain_to(0, "R3");
    extReqN[0] = 1'b1;
    tick(6);
    reti();
    quiet(8, "R3 pin released");
    idle_check("R3");
    extEdgeMode[0] = 1'b1;

    // R5 high beats low
    srcPrioHigh[5] = 1'b1;
    expect_irq(5, 1'b1, "R5 high first");
    expect_irq(3, 1'b0, "R5 low second");
    intReq[1] = 1'b1; intReq[3] = 1'b1;
    tick(1);
    intReq = '0;
    drain_to(1, "R5");
    chk(busyHigh, "R8 high busy", int'(busyHigh), 1);
    quiet(6, "R8 low blocked under high");
    reti();
    drain_to(0, "R5");
    reti();
    idle_check("R5");

    // R5 lower index wins in one level
    expect_irq(2, 1'b0, "R5 index order first");
    expect_irq(4, 1'b0, "R5 index order second");
    intReq[0] = 1'b1; intReq[2] = 1'b1;
    tick(1);
    intReq = '0;
    drain_to(1, "R5");
    reti();
    drain_to(0, "R5");
    reti();

    // R5 unmaskable source over a high source, despite its low setting
    srcPrioHigh[6] = 1'b1;
    srcPrioHigh[7] = 1'b0;
    expect_irq(7, 1'b1, "R5 source 7 wins");
    expect_irq(6, 1'b1, "R5 high after source 7");
    intReq[4] = 1'b1; intReq[5] = 1'b1;
    tick(1);
    intReq = '0;
    drain_to(1, "R5");
    reti();
    drain_to(0, "R5");
    reti();
    idle_check("R5");

    // R4 masking
    srcEnable[3] = 1'b0;
    pulse(3);
    quiet(8, "R4 masked source");
    expect_irq(3, 1'b0, "R4 unmasked keeps flag");
    srcEnable[3] = 1'b1;
    drain_to(0, "R4");
    reti();
    globalEnable = 1'b0;
    pulse(4);
    quiet(8, "R4 global disable");
    srcEnable[7] = 1'b0;
    expect_irq(7, 1'b1, "R4 source 7 ignores enables");
    pulse(7);
    drain_to(0, "R4");
    chk(busyHigh, "R4 source 7 granted", int'(busyHigh), 1);
    reti();
    expect_irq(4, 1'b0, "R4 global re-enable");
    globalEnable = 1'b1;
    drain_to(0, "R4");
    reti();
    srcEnable[7] = 1'b1;
    idle_check("R4");

    // R8 / R9 preemption and return order
    expect_irq(2, 1'b0, "R8 low routine");
    pulse(2);
    drain_to(0, "R8");
    expect_irq(6, 1'b1, "R8 high preempts low");
    pulse(6);
    drain_to(0, "R8");
    chk(busyHigh && busyLow, "R8 both levels busy", {busyHigh, busyLow}, 3);
    pulse(4);
    pulse(5);
    quiet(8, "R8 nothing preempts high");
    expect_irq(5, 1'b1, "R8 high after high returns");
    reti();
    chk(!busyHigh && busyLow, "R9 reti clears high first", {busyHigh, busyLow}, 1);
    drain_to(0, "R8");
    reti();
    quiet(8, "R8 low blocked under low");
    expect_irq(4, 1'b0, "R8 low after low returns");
    reti();
    drain_to(0, "R8");
    reti();
    idle_check("R9");

    // R6 request held while a stronger one arrives
    autoAck = 1'b0;
    pulse(4);
    tick(1);
    chk(irqReq && irqSrc == 3'd4, "R10 internal pulse latency", {irqReq, irqSrc}, 12);
    pulse(6);
    tick(3);
    chk(irqReq && irqSrc == 3'd4 && !irqHigh, "R6 held source", {irqReq, irqSrc}, 12);
    expect_irq(6, 1'b1, "R6 stronger taken after ack");
    ackOnce = 1'b1;
    tick(2);
    autoAck = 1'b1;
    drain_to(0, "R6");
    chk(busyHigh && busyLow, "R6 both busy", {busyHigh, busyLow}, 3);
    reti();
    reti();
    idle_check("R6");

    finish_run();
  end

endmodule